// File: doc/BRIEF.md
# I2C Register Target with Run-Time Address Relocation

This block is an I2C target that fronts a file of 32-bit registers inside the chip. It oversamples SCL and SDA with the chip clock, detects START and STOP, matches the 7-bit device address, acknowledges, and then moves whole registers in either direction. The first byte after a write address byte selects a register (the sub-address). The data bytes that follow arrive most significant byte first, and every fourth byte writes one register. Reads return registers in the same byte order. The sub-address advances after each full register in both directions.

After reset the device answers at one of two default addresses, chosen by a strap input. Software can move the device to a different address with a guarded two-step sequence. First it writes a 32-bit key to an unlock register. Then, in the very next register write, it writes the new 8-bit address byte to a target register. From the next START on, the device answers only at the new address. The unlock and target registers are handled inside the block and are never passed to the register port.

The bus engine states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK and ST_IGNORE. A STOP from any state leads to ST_IDLE. A START from any state, repeated or not, leads to ST_ADDR. After eight address bits, ST_ADDR goes to ST_ADDR_ACK on a match and to ST_IGNORE otherwise. ST_ADDR_ACK goes to ST_RD for a read or to ST_SUB for a write. ST_SUB goes to ST_SUB_ACK, which goes to ST_WR. ST_WR and ST_WR_ACK alternate for each data byte. ST_RD goes to ST_RD_ACK after eight bits. ST_RD_ACK returns to ST_RD when the controller acknowledges and goes to ST_IGNORE when it does not. The address guard has two states. G_LOCKED becomes G_ARMED when the key is written to the unlock register. Any other complete register write returns the guard to G_LOCKED.

Top module: `i2c_reloc_target`

## Requirements
- R1: After reset, with `addr_strap` low the device acknowledges the 7-bit address 0x1A (write byte 0x34), and with it high 0x1B (write byte 0x36). The address byte carries the address in bits 7:1 and R/W in bit 0 (0 = write). No other address is acknowledged.
- R2: START (SDA falls while SCL is high) begins address reception from any state, including in the middle of a transfer (repeated START). STOP (SDA rises while SCL is high) ends the transfer.
- R3: For a non-matching address the device NACKs and keeps SDA released, acknowledging nothing and writing nothing, until the next START.
- R4: In a write, the byte after the address byte is the sub-address. The data bytes form 32-bit words, MSB first. Each fourth data byte issues one single-cycle `reg_wr_en` pulse for the current sub-address, which then increments.
- R5: A write that ends with fewer than four data bytes for a register issues no register write.
- R6: In a read, the device returns the register at the current sub-address, MSB first. After four acknowledged bytes it continues with the next sub-address. A controller NACK ends the data output.
- R7: Writing 0xF9A5A5A5 to register 0xF8 and then, as the next register write, 0x000000XX to register 0xF9 (XX even) moves the device to 7-bit address XX>>1. The old address is then NACKed.
- R8: A write to 0xF9 that does not directly follow the correct key write (wrong key, or another register written in between) leaves the address unchanged.
- R9: Reset returns the device address to the strap-selected default.
- R10: The device changes its SDA drive only while SCL is low, after an SCL falling edge.
- R11: Writes to registers 0xF8 and 0xF9 never appear on the register write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value, always 0 (open drain) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_strap | input | 1 | Chooses the default address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register written |
| reg_wr_data | output | 32 | Word written |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_addr | output | 8 | Register read |
| reg_rd_data | input | 32 | Word returned in the same cycle as reg_rd_en |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it makes START and STOP. They also assume that each SCL level lasts several chip clocks, so that the synchronizer sees every edge, and that reg_rd_data is valid in the cycle of reg_rd_en. The bench drives the bus with fixed phases of ten chip clocks per SCL level and moves SDA only inside the low phase. START and STOP are the only SDA moves made while SCL is high. The bench's register model answers reads combinationally.

// File: rtl/i2c_reloc_pkg.sv
package i2c_reloc_pkg;

    localparam logic [7:0]  REG_UNLOCK   = 8'hF8;
    localparam logic [7:0]  REG_NEWADDR  = 8'hF9;
    localparam logic [31:0] UNLOCK_KEY   = 32'hF9A5A5A5;
    localparam logic [6:0]  DEF_ADDR_LO  = 7'h1A;
    localparam logic [6:0]  DEF_ADDR_HI  = 7'h1B;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;

    typedef enum logic {
        G_LOCKED,
        G_ARMED
    } guard_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_pipe[STAGES-1];
            sda_d <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_addr_guard.sv
module i2c_addr_guard
    import i2c_reloc_pkg::*;
#(
    parameter int AW = 7,
    parameter int SW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap,
    input  logic          commit,
    input  logic [SW-1:0] commit_sub,
    input  logic [DW-1:0] commit_data,
    output logic [AW-1:0] dev_addr
);
    localparam logic [SW-1:0] SUB_UNLOCK = SW'(REG_UNLOCK);
    localparam logic [SW-1:0] SUB_TARGET = SW'(REG_NEWADDR);
    localparam logic [DW-1:0] KEY        = DW'(UNLOCK_KEY);

    guard_state_t  gst;
    logic          moved;
    logic [AW-1:0] new_addr;
    logic          value_ok;

    assign value_ok = (commit_data[DW-1:AW+1] == '0) && !commit_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gst <= G_LOCKED;
        end else if (commit) begin
            unique case (gst)
                G_LOCKED: gst <= (commit_sub == SUB_UNLOCK && commit_data == KEY) ? G_ARMED : G_LOCKED;
                G_ARMED:  gst <= (commit_sub == SUB_UNLOCK && commit_data == KEY) ? G_ARMED : G_LOCKED;
                default:  gst <= G_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moved    <= 1'b0;
            new_addr <= '0;
        end else if (commit && commit_sub == SUB_TARGET && gst == G_ARMED && value_ok) begin
            moved    <= 1'b1;
            new_addr <= commit_data[AW:1];
        end
    end

    assign dev_addr = moved ? new_addr : (strap ? AW'(DEF_ADDR_HI) : AW'(DEF_ADDR_LO));

    // R7
    new_addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(new_addr) |-> $past(commit && commit_sub == SUB_TARGET && gst == G_ARMED));

    // R8
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gst == G_ARMED && $past(gst) != G_ARMED) |-> $past(commit && commit_sub == SUB_UNLOCK && commit_data == KEY));

    // R8
    moved_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moved) |-> $past(gst == G_ARMED));

endmodule

// File: rtl/i2c_reloc_target.sv
module i2c_reloc_target
    import i2c_reloc_pkg::*;
#(
    parameter int NBYTES      = 4,
    parameter int SUB_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_o,
    output logic                sda_oe,
    input  logic                addr_strap,
    output logic                reg_wr_en,
    output logic [SUB_W-1:0]    reg_wr_addr,
    output logic [8*NBYTES-1:0] reg_wr_data,
    output logic                reg_rd_en,
    output logic [SUB_W-1:0]    reg_rd_addr,
    input  logic [8*NBYTES-1:0] reg_rd_data
);
    localparam int DW = 8 * NBYTES;
    localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BW-1:0] LAST_BYTE = BW'(NBYTES - 1);
    localparam logic [SUB_W-1:0] SUB_UNLOCK = SUB_W'(REG_UNLOCK);
    localparam logic [SUB_W-1:0] SUB_TARGET = SUB_W'(REG_NEWADDR);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t       state, nxt;
    logic [3:0]       cnt;
    logic [7:0]       sh;
    logic             rw;
    logic             mack;
    logic [SUB_W-1:0] sub;
    logic [BW-1:0]    bidx;
    logic [DW-9:0]    wbuf;
    logic [DW-1:0]    txbuf;
    logic [6:0]       dev_addr;

    logic             byte_done;
    logic             commit;
    logic [DW-1:0]    commit_data;
    logic             oe_c;
    logic             rd_c;
    logic [SUB_W-1:0] rd_addr_c;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_guard #(.AW(7), .SW(SUB_W), .DW(DW)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap       (addr_strap),
        .commit      (commit),
        .commit_sub  (sub),
        .commit_data (commit_data),
        .dev_addr    (dev_addr)
    );

    assign byte_done   = scl_fall && (cnt == 4'd8);
    assign commit_data = {wbuf, sh};

    // next state
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = (sh[7:1] == dev_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw ? ST_RD : ST_SUB;
                ST_SUB:      if (byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) nxt = ST_WR;
                ST_WR:       if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR;
                ST_RD:       if (scl_fall && cnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack ? ST_RD : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sh    <= '0;
            rw    <= 1'b0;
            mack  <= 1'b0;
            sub   <= '0;
            bidx  <= '0;
            wbuf  <= '0;
            txbuf <= '0;
        end else if (start_det) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (scl_rise && cnt < 4'd8) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) rw <= sh[0];
                        if (state == ST_SUB) begin
                            sub  <= sh;
                            bidx <= '0;
                        end
                        if (state == ST_WR) begin
                            wbuf <= (DW-8)'({wbuf, sh});
                            bidx <= bidx + 1'b1;
                            if (bidx == LAST_BYTE) begin
                                sub  <= sub + 1'b1;
                                bidx <= '0;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            txbuf <= reg_rd_data;
                            bidx  <= '0;
                        end
                    end
                end
                ST_SUB_ACK, ST_WR_ACK: begin
                    if (scl_fall) cnt <= '0;
                end
                ST_RD: begin
                    if (scl_fall) begin
                        txbuf <= {txbuf[DW-2:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            bidx <= bidx + 1'b1;
                            if (bidx == LAST_BYTE) begin
                                bidx  <= '0;
                                sub   <= sub + 1'b1;
                                txbuf <= reg_rd_data;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        oe_c      = 1'b0;
        rd_c      = 1'b0;
        rd_addr_c = sub;
        commit    = 1'b0;
        unique case (state)
            ST_ADDR_ACK: begin
                oe_c = 1'b1;
                rd_c = scl_fall && rw;
            end
            ST_SUB_ACK, ST_WR_ACK: oe_c = 1'b1;
            ST_WR: commit = byte_done && (bidx == LAST_BYTE);
            ST_RD: oe_c = ~txbuf[DW-1];
            ST_RD_ACK: begin
                rd_c      = scl_fall && mack && (bidx == LAST_BYTE);
                rd_addr_c = sub + 1'b1;
            end
            default: ;
        endcase
    end

    assign sda_o       = 1'b0;
    assign sda_oe      = oe_c;
    assign reg_rd_en   = rd_c;
    assign reg_rd_addr = rd_addr_c;
    assign reg_wr_en   = commit && (sub != SUB_UNLOCK) && (sub != SUB_TARGET);
    assign reg_wr_addr = sub;
    assign reg_wr_data = commit_data;

    // R2
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R10
    sda_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R10
    sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R11
    reloc_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_addr != SUB_UNLOCK && reg_wr_addr != SUB_TARGET));

endmodule

// File: tb/tb_i2c_reloc_target.sv
module tb_i2c_reloc_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        strap = 1'b0;
    logic        sda_o, sda_oe;
    logic        reg_wr_en, reg_rd_en;
    logic [7:0]  reg_wr_addr, reg_rd_addr;
    logic [31:0] reg_wr_data, reg_rd_data;
    wire         sda_bus = sda_m & ~(sda_oe & ~sda_o);

    logic [31:0] mem [0:255];
    int          wr_cnt = 0;
    int          errors = 0;
    int          checks = 0;
    int          viol = 0;
    logic        prev_oe = 1'b0;
    logic        prev_scl = 1'b1;

    always #5 clk = ~clk;

    i2c_reloc_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_o       (sda_o),
        .sda_oe      (sda_oe),
        .addr_strap  (strap),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data)
    );

    assign reg_rd_data = mem[reg_rd_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // R10 bus monitor: drive changes while SCL stayed high
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_m && prev_scl) viol <= viol + 1;
        prev_oe  <= sda_oe;
        prev_scl <= scl_m;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(6);
        sda_m = 1'b0; tick(6);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(6);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(6);
            scl_m = 1'b1; tick(10);
            scl_m = 1'b0; tick(4);
        end
        sda_m = 1'b1; tick(6);
        scl_m = 1'b1; tick(5);
        ack = ~sda_bus; tick(5);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(6);
            scl_m = 1'b1; tick(5);
            b = {b[6:0], sda_bus}; tick(5);
            scl_m = 1'b0; tick(4);
        end
        sda_m = ~give_ack; tick(6);
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic probe(input logic [6:0] a, output logic ack);
        bus_start;
        send_byte({a, 1'b0}, ack);
        bus_stop;
    endtask

    task automatic wr_seq(input logic [6:0] a, input logic [7:0] sub, input logic [63:0] bytes,
                          input int n, output logic allack);
        logic ack;
        bus_start;
        send_byte({a, 1'b0}, ack); allack = ack;
        send_byte(sub, ack); allack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(bytes[8*(n-1-i) +: 8], ack);
            allack &= ack;
        end
        bus_stop;
    endtask

    task automatic rd_seq(input logic [6:0] a, input logic [7:0] sub, input int n, output logic [63:0] got);
        logic ack;
        logic [7:0] b;
        got = '0;
        bus_start;
        send_byte({a, 1'b0}, ack);
        send_byte(sub, ack);
        bus_start;
        send_byte({a, 1'b1}, ack);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            got = {got[55:0], b};
        end
        bus_stop;
    endtask

    task automatic do_reset;
        scl_m = 1'b1; sda_m = 1'b1;
        rst_n = 1'b0; tick(5);
        rst_n = 1'b1; tick(5);
    endtask

    initial begin
        tick(190000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack, allack;
        logic [63:0] got;
        int base;

        do_reset;
        // R9 reset state
        chk(sda_oe == 1'b0 && reg_wr_en == 1'b0, "R9 reset outputs", {62'd0, sda_oe, reg_wr_en}, 64'd0);

        // R1 / R3 address sweep for both straps
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            tick(4);
            for (int a = 0; a < 128; a++) begin
                probe(a[6:0], ack);
                chk(ack == (a == 8'h1A + s), "R1 address sweep", {63'd0, ack}, {63'd0, (a == 8'h1A + s)});
            end
        end
        strap = 1'b0;
        chk(wr_cnt == 0, "R3 sweep wrote nothing", wr_cnt, 0);

        // R4 single register write
        wr_seq(7'h1A, 8'h10, 64'h11223344, 4, allack);
        chk(allack, "R4 write acks", {63'd0, allack}, 1);
        chk(mem[8'h10] == 32'h11223344, "R4 word MSB first", mem[8'h10], 64'h11223344);
        chk(wr_cnt == 1, "R4 one pulse", wr_cnt, 1);

        // R3 nack, then further bytes ignored
        bus_start;
        send_byte({7'h1B, 1'b0}, ack);
        chk(!ack, "R3 mismatch nack", {63'd0, ack}, 0);
        send_byte(8'h10, ack);
        chk(!ack, "R3 stays released", {63'd0, ack}, 0);
        for (int i = 0; i < 4; i++) send_byte(8'hEE, ack);
        bus_stop;
        chk(wr_cnt == 1 && mem[8'h10] == 32'h11223344, "R3 no write", mem[8'h10], 64'h11223344);

        // R4 auto increment
        wr_seq(7'h1A, 8'h20, 64'hA1B2C3D4_0F1E2D3C, 8, allack);
        chk(mem[8'h20] == 32'hA1B2C3D4, "R4 first reg", mem[8'h20], 64'hA1B2C3D4);
        chk(mem[8'h21] == 32'h0F1E2D3C, "R4 incremented reg", mem[8'h21], 64'h0F1E2D3C);

        // R5 partial word sweep
        base = wr_cnt;
        for (int n = 0; n < 4; n++) begin
            wr_seq(7'h1A, 8'h30, 64'h00AABBCC, n, allack);
            chk(wr_cnt == base, "R5 partial not committed", wr_cnt, base);
        end

        // R6 / R2 read with repeated start
        mem[8'h40] = 32'hDEADBEEF;
        mem[8'h41] = 32'h01234567;
        rd_seq(7'h1A, 8'h40, 8, got);
        chk(got == 64'hDEADBEEF_01234567, "R6 R2 two-register read", got, 64'hDEADBEEF_01234567);
        rd_seq(7'h1A, 8'h41, 2, got);
        chk(got == 64'h0123, "R6 nack ends read", got, 64'h0123);

        // R2 STOP mid-transfer, next transfer intact
        bus_start;
        send_byte({7'h1A, 1'b0}, ack);
        send_byte(8'h50, ack);
        send_byte(8'h99, ack);
        bus_stop;
        wr_seq(7'h1A, 8'h51, 64'h55667788, 4, allack);
        chk(mem[8'h51] == 32'h55667788 && allack, "R2 stop then fresh write", mem[8'h51], 64'h55667788);

        // R8 target write without arming
        base = wr_cnt;
        wr_seq(7'h1A, 8'hF9, 64'h00000050, 4, allack);
        probe(7'h28, ack);
        chk(!ack, "R8 unarmed write ignored", {63'd0, ack}, 0);
        // R8 wrong key
        wr_seq(7'h1A, 8'hF8, 64'hF9A5A5A4, 4, allack);
        wr_seq(7'h1A, 8'hF9, 64'h00000050, 4, allack);
        probe(7'h28, ack);
        chk(!ack, "R8 wrong key ignored", {63'd0, ack}, 0);
        // R8 intervening write
        wr_seq(7'h1A, 8'hF8, 64'hF9A5A5A5, 4, allack);
        wr_seq(7'h1A, 8'h12, 64'h00000001, 4, allack);
        wr_seq(7'h1A, 8'hF9, 64'h00000050, 4, allack);
        probe(7'h28, ack);
        chk(!ack, "R8 intervening write disarms", {63'd0, ack}, 0);
        probe(7'h1A, ack);
        chk(ack, "R8 old address kept", {63'd0, ack}, 1);

        // R7 valid relocation
        wr_seq(7'h1A, 8'hF8, 64'hF9A5A5A5, 4, allack);
        wr_seq(7'h1A, 8'hF9, 64'h00000050, 4, allack);
        probe(7'h28, ack);
        chk(ack, "R7 new address acks", {63'd0, ack}, 1);
        probe(7'h1A, ack);
        chk(!ack, "R7 old address nacked", {63'd0, ack}, 0);
        chk(wr_cnt == base + 1, "R11 unlock and target not forwarded", wr_cnt, base + 1);
        wr_seq(7'h28, 8'h11, 64'hCAFEF00D, 4, allack);
        chk(mem[8'h11] == 32'hCAFEF00D, "R7 write at new address", mem[8'h11], 64'hCAFEF00D);

        // R9 reset restores default
        do_reset;
        probe(7'h1A, ack);
        chk(ack, "R9 default after reset", {63'd0, ack}, 1);
        probe(7'h28, ack);
        chk(!ack, "R9 moved address dropped", {63'd0, ack}, 0);
        strap = 1'b1;
        tick(4);
        probe(7'h1B, ack);
        chk(ack, "R1 R9 strap high default", {63'd0, ack}, 1);

        // R10 drive changed only while SCL low
        chk(viol == 0, "R10 SDA drive timing", viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule